// File: doc/BRIEF.md
# Scan Chain Flush Tester

This block verifies that a scan shift register is intact before any test vectors are sent through it. After a start request it holds the test-control line at the scan-mode level, so the chain only shifts. It then pushes a periodic stimulus into the chain's serial input. The stimulus is two zeros followed by two ones, repeated, and it is four bits longer than the chain. Because of this, every cell sees a 0-to-0, 0-to-1, 1-to-1 and 1-to-0 transition.

The only place the result is observed is the chain's serial output. Each bit that comes out is compared with the stimulus bit that was driven exactly one chain length of cycles earlier. Comparison waits until the first stimulus bit has had time to reach the far end of the chain, so whatever the chain held before the flush is ignored. Any mismatch is remembered. When the last expected bit has been compared, the block returns test control to the functional level and raises a done flag with a pass/fail verdict. The block covers only this integrity flush. It does not apply vectors, pulse capture clocks, or locate a faulty cell.

Top module: `scan_flush_tester`

## Requirements
- R1: While reset is high and in the first cycle after it, test_ctl is 1, scan_in is 0, done is 0 and pass is 0.
- R2: A start sampled while no flush is running drives test_ctl to 0 from the next clock. It stays 0 for exactly 2*CHAIN_LEN+4 consecutive cycles.
- R3: Number the low test_ctl cycles k = 0, 1, 2, and so on. In cycle k, scan_in is bit 1 of k (giving the sequence 0,0,1,1,0,0,...) for k < CHAIN_LEN+4, and 0 after that. Whenever test_ctl is 1, scan_in is 0.
- R4: A chain of exactly CHAIN_LEN working cells gives pass = 1, whatever the chain held before the flush.
- R5: A serial output stuck at 0, or stuck at 1, gives pass = 0.
- R6: A single cell stuck at either value, at any position in the chain, gives pass = 0.
- R7: A chain that is one, two or three cells shorter or longer than CHAIN_LEN gives pass = 0.
- R8: done rises on the same clock edge that ends the last low test_ctl cycle. test_ctl returns to 1 on that same edge, and pass is valid whenever done is 1 (pass is 1 only while done is 1).
- R9: A start that arrives while a flush is running has no effect. The low window keeps its length of 2*CHAIN_LEN+4 cycles.
- R10: done and pass hold their values until the next accepted start. That start clears both on the clock edge where it is sampled.
- R11: During a flush of a working chain, every cell passes through all four transitions: 0 to 0, 0 to 1, 1 to 1 and 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, shared with the scan chain |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run one flush |
| scan_out | input | 1 | Serial output from the last chain cell |
| test_ctl | output | 1 | Test control; 0 selects shift mode for the chain |
| scan_in | output | 1 | Serial stimulus into the first chain cell |
| done | output | 1 | The flush is complete and the verdict is valid |
| pass | output | 1 | 1 when every compared bit matched |

## Verification
The hardest case to reach is a chain whose length is off by only a cell or two, combined with leftover contents that happen to match the first compared bits. A bench with one fixed model can produce neither. The bench therefore models the chain with a length that can be changed at run time, and with cells that can be stuck at chosen positions. Before each flush it preloads the chain with random bits. Directed runs cover both ends of the chain and the one-cell length errors. Randomly drawn runs then mix length offsets, stuck positions and stuck values, all against a verdict the bench computes itself.

// File: rtl/scan_flush_pkg.sv
package scan_flush_pkg;

  typedef enum logic [1:0] {
    FL_IDLE = 2'd0,
    FL_RUN  = 2'd1,
    FL_DONE = 2'd2
  } flush_state_e;

  // Period-four stimulus: two zeros, then two ones.
  function automatic logic flush_pat(input logic [31:0] idx);
    return idx[1];
  endfunction

endpackage

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import scan_flush_pkg::*;
#(
  parameter int CHAIN_LEN = 16,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             run,
  output logic             go,
  output logic             last,
  output logic             cmp_en,
  output logic [CNT_W-1:0] cnt,
  output logic             test_ctl,
  output logic             done
);
  localparam int STIM_LEN = CHAIN_LEN + 4;
  localparam int TOTAL    = CHAIN_LEN + STIM_LEN;

  flush_state_e st_q;

  assign run    = (st_q == FL_RUN);
  assign go     = start && !run;
  assign last   = run && (32'(cnt) == TOTAL - 1);
  assign cmp_en = run && (32'(cnt) >= CHAIN_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= FL_IDLE;
      cnt      <= '0;
      test_ctl <= 1'b1;
      done     <= 1'b0;
    end else if (go) begin
      st_q     <= FL_RUN;
      cnt      <= '0;
      test_ctl <= 1'b0;
      done     <= 1'b0;
    end else if (last) begin
      st_q     <= FL_DONE;
      test_ctl <= 1'b1;
      done     <= 1'b1;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sft_stim.sv
module sft_stim
  import scan_flush_pkg::*;
#(
  parameter int CHAIN_LEN = 16,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  output logic             scan_in
);
  localparam int STIM_LEN = CHAIN_LEN + 4;

  logic [31:0] nxt_idx;
  assign nxt_idx = 32'(cnt) + 32'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_in <= 1'b0;
    end else if (go) begin
      scan_in <= flush_pat(32'd0);
    end else if (run && (nxt_idx < 32'(STIM_LEN))) begin
      scan_in <= flush_pat(nxt_idx);
    end else begin
      scan_in <= 1'b0;
    end
  end
endmodule

// File: rtl/sft_ref_delay.sv
module sft_ref_delay #(
  parameter int CHAIN_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic scan_in,
  output logic exp_bit
);
  logic [CHAIN_LEN-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (run) begin
      line_q <= {line_q[CHAIN_LEN-2:0], scan_in};
    end
  end

  assign exp_bit = line_q[CHAIN_LEN-1];
endmodule

// File: rtl/sft_cmp.sv
module sft_cmp (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic last,
  input  logic cmp_en,
  input  logic exp_bit,
  input  logic scan_out,
  output logic pass
);
  logic fail_q;
  logic miss;

  assign miss = cmp_en && (scan_out != exp_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= 1'b0;
      pass   <= 1'b0;
    end else if (go) begin
      fail_q <= 1'b0;
      pass   <= 1'b0;
    end else begin
      if (miss) fail_q <= 1'b1;
      if (last) pass <= !(fail_q || miss);
    end
  end
endmodule

// File: rtl/scan_flush_tester.sv
module scan_flush_tester
  import scan_flush_pkg::*;
#(
  parameter int CHAIN_LEN      = 16,
  parameter bit USE_DELAY_LINE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic scan_out,
  output logic test_ctl,
  output logic scan_in,
  output logic done,
  output logic pass
);
  localparam int TOTAL = 2 * CHAIN_LEN + 4;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic             run, go, last, cmp_en, exp_bit;
  logic [CNT_W-1:0] cnt;

  sft_ctrl #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .run(run), .go(go), .last(last),
    .cmp_en(cmp_en), .cnt(cnt), .test_ctl(test_ctl), .done(done)
  );

  sft_stim #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) stim_i (
    .clk(clk), .rst(rst), .go(go), .run(run), .cnt(cnt), .scan_in(scan_in)
  );

  generate
    if (USE_DELAY_LINE) begin : g_line
      sft_ref_delay #(.CHAIN_LEN(CHAIN_LEN)) ref_i (
        .clk(clk), .rst(rst), .run(run), .scan_in(scan_in), .exp_bit(exp_bit)
      );
    end else begin : g_count
      // Expected bit is the one driven CHAIN_LEN cycles earlier.
      assign exp_bit = flush_pat(32'(cnt) - 32'(CHAIN_LEN));
    end
  endgenerate

  sft_cmp cmp_i (
    .clk(clk), .rst(rst), .go(go), .last(last), .cmp_en(cmp_en),
    .exp_bit(exp_bit), .scan_out(scan_out), .pass(pass)
  );
endmodule

// File: rtl/scan_flush_tester_chk.sv
module scan_flush_tester_chk #(
  parameter int CHAIN_LEN = 16
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic test_ctl,
  input logic scan_in,
  input logic done,
  input logic pass
);
  localparam int TOTAL = 2 * CHAIN_LEN + 4;

  int low_cnt;
  always_ff @(posedge clk) begin
    if (rst || test_ctl) low_cnt <= 0;
    else                 low_cnt <= low_cnt + 1;
  end

  a_r2_window_len: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (low_cnt == TOTAL));
  a_r2_fall_on_start: assert property (@(posedge clk) disable iff (rst)
    $fell(test_ctl) |-> $past(start));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    test_ctl |-> !scan_in);
  a_r8_done_func_mode: assert property (@(posedge clk) disable iff (rst)
    done |-> test_ctl);
  a_r8_pass_with_done: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);
  a_r9_no_early_end: assert property (@(posedge clk) disable iff (rst)
    (!test_ctl && start) |=> (!test_ctl || done));
  a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(start));
  a_r10_pass_hold: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done) && !$past(start)) |-> $stable(pass));
endmodule

bind scan_flush_tester scan_flush_tester_chk #(.CHAIN_LEN(CHAIN_LEN)) chk_i (
  .clk(clk), .rst(rst), .start(start), .test_ctl(test_ctl),
  .scan_in(scan_in), .done(done), .pass(pass)
);

// File: tb/scan_flush_tester_tb_top.sv
`timescale 1ns/1ps
module scan_flush_tester_tb_top;
  localparam int CHAIN_LEN = 16;
  localparam int MAXL      = CHAIN_LEN + 3;
  localparam int STIM      = CHAIN_LEN + 4;
  localparam int TOTAL     = 2 * CHAIN_LEN + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic scan_out, test_ctl, scan_in, done, pass;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Chain model with run-time length and fault injection.
  logic [MAXL-1:0] chain;
  logic [MAXL-1:0] preload = '0;
  logic [3:0] seen [MAXL];
  logic load_req = 1'b0;
  int   act_len = CHAIN_LEN;
  int   stuck_pos = -1;
  logic stuck_val = 1'b0;
  int   sout_mode = 0;

  always #2.5 clk = ~clk;

  scan_flush_tester #(.CHAIN_LEN(CHAIN_LEN)) dut_i (
    .clk(clk), .rst(rst), .start(start), .scan_out(scan_out),
    .test_ctl(test_ctl), .scan_in(scan_in), .done(done), .pass(pass)
  );

  assign scan_out = (sout_mode == 1) ? 1'b0 :
                    (sout_mode == 2) ? 1'b1 : chain[act_len-1];

  always @(posedge clk) begin
    logic [MAXL-1:0] shifted;
    logic nv;
    shifted = {chain[MAXL-2:0], scan_in};
    if (load_req) begin
      chain <= preload;
      for (int i = 0; i < MAXL; i++) seen[i] <= 4'h0;
    end else if (!test_ctl) begin
      for (int i = 0; i < MAXL; i++) begin
        nv = (i == stuck_pos) ? stuck_val : shifted[i];
        chain[i] <= nv;
        seen[i][{chain[i], nv}] <= 1'b1;
      end
    end
  end

  function automatic logic exp_bit(input int k);
    return (k < STIM) ? logic'((k >> 1) & 1) : 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int len, input int spos, input logic sval,
                          input int sout, input bit mid_start, input string req);
    bit exp_pass;
    int k, bad;
    exp_pass = (len == CHAIN_LEN) && (spos < 0) && (sout == 0);
    @(negedge clk);
    act_len = len; stuck_pos = spos; stuck_val = sval; sout_mode = sout;
    for (int i = 0; i < MAXL; i++) preload[i] = logic'($urandom & 1);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && !pass, "R10 clear on start", {30'd0, done, pass}, 0);
    k = 0; bad = 0;
    while (!done && k < TOTAL + 10) begin
      if (!test_ctl) begin
        if (scan_in !== exp_bit(k)) bad++;
        start = (mid_start && k == TOTAL / 2);
        k++;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(k == TOTAL, mid_start ? "R9 window with extra start" : "R2 window length", k, TOTAL);
    check(bad == 0, "R3 stimulus bits", bad, 0);
    check(done && test_ctl, "R8 done with functional mode", {30'd0, done, test_ctl}, 3);
    check(pass == exp_pass, req, int'(pass), int'(exp_pass));
    if (exp_pass) begin
      int miss = 0;
      for (int i = 0; i < len; i++) if (seen[i] != 4'hF) miss++;
      check(miss == 0, "R11 all transitions per cell", miss, 0);
    end
    repeat (3) @(negedge clk);
    check(done && pass == exp_pass, "R10 verdict holds", int'(pass), int'(exp_pass));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(test_ctl && !scan_in && !done && !pass, "R1 reset state",
          {28'd0, test_ctl, scan_in, done, pass}, 8);
    rst = 1'b0;
    @(negedge clk);
    check(test_ctl && !scan_in && !done && !pass, "R1 after reset",
          {28'd0, test_ctl, scan_in, done, pass}, 8);

    run_case(CHAIN_LEN, -1, 1'b0, 0, 1'b0, "R4 intact chain passes");
    run_case(CHAIN_LEN, -1, 1'b0, 0, 1'b1, "R9 intact chain with extra start");
    run_case(CHAIN_LEN, -1, 1'b0, 1, 1'b0, "R5 output stuck at 0");
    run_case(CHAIN_LEN, -1, 1'b0, 2, 1'b0, "R5 output stuck at 1");
    run_case(CHAIN_LEN, 0, 1'b0, 0, 1'b0, "R6 first cell stuck at 0");
    run_case(CHAIN_LEN, CHAIN_LEN - 1, 1'b1, 0, 1'b0, "R6 last cell stuck at 1");
    run_case(CHAIN_LEN - 1, -1, 1'b0, 0, 1'b0, "R7 one cell short");
    run_case(CHAIN_LEN + 1, -1, 1'b0, 0, 1'b0, "R7 one cell long");

    for (int n = 0; n < 16; n++) begin
      int kind, d;
      kind = int'($urandom % 3);
      if (kind == 0) begin
        run_case(CHAIN_LEN, -1, 1'b0, 0, 1'b0, "R4 random intact chain");
      end else if (kind == 1) begin
        run_case(CHAIN_LEN, int'($urandom % CHAIN_LEN), logic'($urandom & 1), 0, 1'b0,
                 "R6 random stuck cell");
      end else begin
        d = int'($urandom % 3) + 1;
        if ($urandom & 1) d = -d;
        run_case(CHAIN_LEN + d, -1, 1'b0, 0, 1'b0, "R7 random length offset");
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule